// File: doc/BRIEF.md
# Radix-16 Remainder Update with Semidynamic Divisor Multiples

This block performs the remainder recurrence of a radix-16 digit-recurrence divider. In each iteration it computes W' = 16·W − q·D for a quotient digit q in [−9, 9]. Quotient digit selection is not part of the block. An external selector looks at the current remainder and drives the digit for each iteration. The block returns the remainder in carry-save form, so the recurrence never waits on a carry chain.

Only three divisor multiples are held: 2D, 3D and 6D. They are computed in one set-up cycle after the start pulse. Each digit is split into a coarse part of −6, 0 or +6 and a fine part of magnitude 0..3 with its own sign. The remainder shifted left by four is combined with both +6D and −6D before the digit is known, so that work overlaps with digit selection. Once the digit arrives, one of three carry-save candidates is chosen. A four-way selector then picks 0, D, 2D or 3D, and a second carry-save addition adds or subtracts that multiple. This gives magnitudes 4 and 5 as 6D−2D and 6D−D, and magnitudes 6..9 as 6D plus 0..3 multiples of D.

Operands are fixed point with FRAC fraction bits. The divisor is an unsigned fraction in [1/16, 1). The dividend is a signed value of FRAC+1 bits. The remainder is FRAC+6 bits wide and wraps modulo 2^(FRAC+6).

Top module: `semidyn_rem_update`

## Requirements
- R1: After reset, busy_o and done_o are 0 and rem_sum_o + rem_carry_o equals 0.
- R2: On the clock edge where start_i is high, the divisor is captured and the remainder is set to the sign-extended dividend with a zero carry vector. From the next cycle, busy_o is 1 and done_o is 0.
- R3: The cycle after the start edge is a set-up cycle that computes 2D, 3D and 6D. The remainder does not change in that cycle, whatever value digit_i has.
- R4: In each iteration cycle, digit_i (5-bit two's complement, legal range −9..9) is consumed. The new remainder satisfies rem_sum_o + rem_carry_o = 16·W − digit·D modulo 2^(FRAC+6).
- R5: The digit is split into a coarse term of −6, 0 or +6 (|q| ≥ 4 takes ±6) and a fine term of magnitude 0..3. The fine term is added or subtracted. For a negative digit both parts are negated, so 6·coarse + fine equals the digit. Magnitudes 4 and 5 use a fine term of −2 and −1 relative to 6.
- R6: After exactly ITERS iteration cycles, done_o goes to 1 and busy_o to 0. From then on, digit_i has no effect on the remainder.
- R7: done_o stays 1 until the next start pulse. A start pulse in any state, including mid-division, begins a new division and clears done_o.
- R8: When each digit is the rounded value of 16·W/D clipped to [−9, 9], every remainder satisfies |W| ≤ 0.6·D. After the last iteration, X·16^ITERS = Q·D + W, where Q is the digits read as a radix-16 number.
- R9: While idle, in set-up or done, with start_i low, the remainder registers hold their value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begins a division; captures operands |
| dividend_i | input | FRAC+1 | Signed fixed-point dividend |
| divisor_i | input | FRAC | Unsigned divisor fraction, at least 1/16 |
| digit_i | input | 5 | Signed quotient digit for the current iteration |
| busy_o | output | 1 | Set-up or iteration in progress |
| done_o | output | 1 | All iterations complete |
| rem_sum_o | output | FRAC+6 | Remainder sum vector |
| rem_carry_o | output | FRAC+6 | Remainder carry vector |

## Verification
On every cycle, the assertions check that the coarse and fine parts recombine to the applied digit, and that the held multiples keep their ratios and stay constant while iterating. They also check that the remainder is frozen outside iteration and that done appears only after the full iteration count. The arithmetic value of the carry-save remainder, its convergence bound and the final identity X·16^ITERS = Q·D + W can only be shown by the bench scenarios. These scenarios include rounded-digit runs over several divisors and runs that force every digit value from −9 to 9.

// File: rtl/dmc_pkg.sv
package dmc_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_INIT = 2'd1,
    ST_ITER = 2'd2,
    ST_DONE = 2'd3
  } dmc_state_t;

  // coarse part: add_6d means +6D, sub_6d means -6D
  // fine part: fine_mag * D, subtracted when fine_sub
  typedef struct packed {
    logic       add_6d;
    logic       sub_6d;
    logic       fine_sub;
    logic [1:0] fine_mag;
  } digit_split_t;

  // remainder update subtracts q*D; split |q| = 6a + b, b in [-2,3]
  function automatic digit_split_t split_digit(input logic signed [4:0] q);
    digit_split_t r;
    logic         neg;
    logic [3:0]   mag;
    logic [3:0]   b;
    neg = q[4];
    mag = neg ? (~q[3:0] + 4'd1) : q[3:0];
    if (mag >= 4'd4) begin
      b = mag - 4'd6;
      r.sub_6d = ~neg;
      r.add_6d = neg;
    end else begin
      b = mag;
      r.sub_6d = 1'b0;
      r.add_6d = 1'b0;
    end
    r.fine_mag = b[3] ? (~b[1:0] + 2'd1) : b[1:0];
    r.fine_sub = (b != 4'd0) && (b[3] ? neg : ~neg);
    return r;
  endfunction

endpackage

// File: rtl/dmc_csa.sv
module dmc_csa #(
  parameter int W = 22
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic [W-1:0] c_i,
  input  logic         cin_i,
  output logic [W-1:0] sum_o,
  output logic [W-1:0] cy_o
);
  logic [W-1:0] maj;
  always_comb begin
    sum_o = a_i ^ b_i ^ c_i;
    maj   = (a_i & b_i) | (a_i & c_i) | (b_i & c_i);
    cy_o  = (maj << 1) | {{(W-1){1'b0}}, cin_i};
  end
endmodule

// File: rtl/dmc_multiples.sv
module dmc_multiples #(
  parameter int FRAC = 16,
  parameter int WW   = FRAC + 6
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            load_i,
  input  logic [FRAC-1:0] d_i,
  output logic [WW-1:0]   m2_o,
  output logic [WW-1:0]   m3_o,
  output logic [WW-1:0]   m6_o
);
  localparam int PADW = WW - FRAC;
  logic [WW-1:0] d_ext, d2, d4;
  always_comb begin
    d_ext = {{PADW{1'b0}}, d_i};
    d2    = d_ext << 1;
    d4    = d_ext << 2;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m2_o <= '0;
      m3_o <= '0;
      m6_o <= '0;
    end else if (load_i) begin
      m2_o <= d2;
      m3_o <= d2 + d_ext;
      m6_o <= d4 + d2;
    end
  end
endmodule

// File: rtl/dmc_spec_stage.sv
module dmc_spec_stage #(
  parameter int WW = 22
) (
  input  logic [WW-1:0] ws_i,
  input  logic [WW-1:0] wc_i,
  input  logic [WW-1:0] m6_i,
  input  logic          add_6d_i,
  input  logic          sub_6d_i,
  output logic [WW-1:0] ps_o,
  output logic [WW-1:0] pc_o
);
  logic [WW-1:0] s16, c16;
  logic [WW-1:0] cand_s [2];
  logic [WW-1:0] cand_c [2];

  always_comb begin
    s16 = ws_i << 4;
    c16 = wc_i << 4;
  end

  // index 0: 16W + 6D, index 1: 16W - 6D; both built before the digit lands
  for (genvar k = 0; k < 2; k++) begin : g_cand
    logic [WW-1:0] opnd;
    assign opnd = (k == 1) ? ~m6_i : m6_i;
    dmc_csa #(.W(WW)) u_csa (
      .a_i   (s16),
      .b_i   (c16),
      .c_i   (opnd),
      .cin_i (k == 1),
      .sum_o (cand_s[k]),
      .cy_o  (cand_c[k])
    );
  end

  always_comb begin
    if (add_6d_i) begin
      ps_o = cand_s[0];
      pc_o = cand_c[0];
    end else if (sub_6d_i) begin
      ps_o = cand_s[1];
      pc_o = cand_c[1];
    end else begin
      ps_o = s16;
      pc_o = c16;
    end
  end
endmodule

// File: rtl/dmc_fine_stage.sv
module dmc_fine_stage #(
  parameter int WW = 22
) (
  input  logic [WW-1:0] ps_i,
  input  logic [WW-1:0] pc_i,
  input  logic [WW-1:0] d_i,
  input  logic [WW-1:0] m2_i,
  input  logic [WW-1:0] m3_i,
  input  logic [1:0]    mag_i,
  input  logic          sub_i,
  output logic [WW-1:0] ns_o,
  output logic [WW-1:0] nc_o
);
  logic [WW-1:0] pick, opnd;
  always_comb begin
    unique case (mag_i)
      2'd0:    pick = '0;
      2'd1:    pick = d_i;
      2'd2:    pick = m2_i;
      default: pick = m3_i;
    endcase
    opnd = sub_i ? ~pick : pick;
  end

  dmc_csa #(.W(WW)) u_csa (
    .a_i   (ps_i),
    .b_i   (pc_i),
    .c_i   (opnd),
    .cin_i (sub_i),
    .sum_o (ns_o),
    .cy_o  (nc_o)
  );
endmodule

// File: rtl/semidyn_rem_update.sv
module semidyn_rem_update #(
  parameter int FRAC  = 16,
  parameter int ITERS = 14
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  logic signed [FRAC:0] dividend_i,
  input  logic [FRAC-1:0]     divisor_i,
  input  logic signed [4:0]   digit_i,
  output logic                busy_o,
  output logic                done_o,
  output logic [FRAC+5:0]     rem_sum_o,
  output logic [FRAC+5:0]     rem_carry_o
);
  import dmc_pkg::*;

  localparam int WW   = FRAC + 6;
  localparam int CW   = $clog2(ITERS + 1);
  localparam int SEXT = WW - FRAC - 1;

  dmc_state_t    state_q;
  logic [FRAC-1:0] d_q;
  logic [CW-1:0] cnt_q;
  logic [WW-1:0] d_ext, m2, m3, m6;
  logic [WW-1:0] part_s, part_c, nxt_s, nxt_c;
  logic          init_en, iter_en, last_iter;
  digit_split_t  split;

  assign init_en   = (state_q == ST_INIT) && !start_i;
  assign iter_en   = (state_q == ST_ITER) && !start_i;
  assign last_iter = (cnt_q == CW'(ITERS - 1));
  assign d_ext     = {{(WW-FRAC){1'b0}}, d_q};
  assign split     = split_digit(digit_i);

  dmc_multiples #(.FRAC(FRAC), .WW(WW)) u_mult (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (init_en),
    .d_i    (d_q),
    .m2_o   (m2),
    .m3_o   (m3),
    .m6_o   (m6)
  );

  dmc_spec_stage #(.WW(WW)) u_spec (
    .ws_i     (rem_sum_o),
    .wc_i     (rem_carry_o),
    .m6_i     (m6),
    .add_6d_i (split.add_6d),
    .sub_6d_i (split.sub_6d),
    .ps_o     (part_s),
    .pc_o     (part_c)
  );

  dmc_fine_stage #(.WW(WW)) u_fine (
    .ps_i  (part_s),
    .pc_i  (part_c),
    .d_i   (d_ext),
    .m2_i  (m2),
    .m3_i  (m3),
    .mag_i (split.fine_mag),
    .sub_i (split.fine_sub),
    .ns_o  (nxt_s),
    .nc_o  (nxt_c)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      d_q         <= '0;
      cnt_q       <= '0;
      rem_sum_o   <= '0;
      rem_carry_o <= '0;
    end else if (start_i) begin
      state_q     <= ST_INIT;
      d_q         <= divisor_i;
      cnt_q       <= '0;
      rem_sum_o   <= {{SEXT{dividend_i[FRAC]}}, dividend_i};
      rem_carry_o <= '0;
    end else begin
      unique case (state_q)
        ST_INIT: state_q <= ST_ITER;
        ST_ITER: begin
          rem_sum_o   <= nxt_s;
          rem_carry_o <= nxt_c;
          cnt_q       <= cnt_q + CW'(1);
          if (last_iter) state_q <= ST_DONE;
        end
        default: state_q <= state_q;
      endcase
    end
  end

  assign busy_o = (state_q == ST_INIT) || (state_q == ST_ITER);
  assign done_o = (state_q == ST_DONE);

endmodule

// File: rtl/semidyn_rem_update_chk.sv
module semidyn_rem_update_chk #(
  parameter int FRAC  = 16,
  parameter int ITERS = 14,
  parameter int WW    = FRAC + 6
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic signed [4:0] digit_i,
  input logic              iter_en,
  input logic              busy_o,
  input logic              done_o,
  input logic [WW-1:0]     rem_sum_o,
  input logic [WW-1:0]     rem_carry_o,
  input logic [WW-1:0]     d_ext,
  input logic [WW-1:0]     m2,
  input logic [WW-1:0]     m3,
  input logic [WW-1:0]     m6,
  input logic              add_6d,
  input logic              sub_6d,
  input logic              fine_sub,
  input logic [1:0]        fine_mag
);
  int seen_iters;
  int recombined;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       seen_iters <= 0;
    else if (start_i)  seen_iters <= 0;
    else if (iter_en)  seen_iters <= seen_iters + 1;
  end

  always_comb begin
    recombined = 6 * (int'(sub_6d) - int'(add_6d))
               + (fine_sub ? int'(fine_mag) : -int'(fine_mag));
  end

  p_digit_legal_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    iter_en |-> (digit_i >= -5'sd9) && (digit_i <= 5'sd9));

  p_coarse_onehot_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({add_6d, sub_6d}));

  p_split_recombine_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    iter_en |-> recombined == int'(digit_i));

  p_mult_ratio_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    iter_en |-> (m6 == WW'(m2 * 3)) && (m3 == WW'(m2 + d_ext)));

  p_mult_const_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (iter_en && $past(iter_en)) |-> $stable(m6) && $stable(m3) && $stable(m2));

  p_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!start_i && !iter_en) |=> $stable(rem_sum_o) && $stable(rem_carry_o));

  p_done_count_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> seen_iters == ITERS);

  p_flags_excl_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && busy_o));

  p_start_clears_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> busy_o && !done_o);

endmodule

bind semidyn_rem_update semidyn_rem_update_chk #(
  .FRAC(FRAC), .ITERS(ITERS), .WW(WW)
) chk_i (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .start_i     (start_i),
  .digit_i     (digit_i),
  .iter_en     (iter_en),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .rem_sum_o   (rem_sum_o),
  .rem_carry_o (rem_carry_o),
  .d_ext       (d_ext),
  .m2          (m2),
  .m3          (m3),
  .m6          (m6),
  .add_6d      (split.add_6d),
  .sub_6d      (split.sub_6d),
  .fine_sub    (split.fine_sub),
  .fine_mag    (split.fine_mag)
);

// File: tb/semidyn_rem_update_tb_top.sv
module semidyn_rem_update_tb_top;
  localparam int FRAC  = 16;
  localparam int ITERS = 14;
  localparam int WW    = FRAC + 6;
  localparam int NV    = 8;
  localparam int VX [NV] = '{12345, -20000, 39000, -2457, 100, 0, -39321, 1000};
  localparam int VD [NV] = '{40000, 50000, 65535, 4096, 4096, 33333, 65535, 20000};

  logic                 clk = 1'b0;
  logic                 rst_n = 1'b0;
  logic                 start = 1'b0;
  logic signed [FRAC:0] dividend = '0;
  logic [FRAC-1:0]      divisor = '0;
  logic signed [4:0]    digit = '0;
  logic                 busy, done;
  logic [WW-1:0]        rsum, rcar;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  semidyn_rem_update #(.FRAC(FRAC), .ITERS(ITERS)) dut_i (
    .clk_i (clk), .rst_ni (rst_n), .start_i (start),
    .dividend_i (dividend), .divisor_i (divisor), .digit_i (digit),
    .busy_o (busy), .done_o (done),
    .rem_sum_o (rsum), .rem_carry_o (rcar)
  );

  function automatic logic [WW-1:0] rem_now();
    return rsum + rcar;
  endfunction

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic check_rem(input string req, input logic signed [127:0] w);
    logic [WW-1:0] r;
    r = rem_now();
    check(r == w[WW-1:0], req, longint'($signed(r)), longint'($signed(w[WW-1:0])));
  endtask

  task automatic run_div(input int xv, input int dv, input bit forced, input int seed);
    logic signed [127:0] w, qacc, num, den, qq, lhs, rhs;
    @(negedge clk);
    start = 1'b1; dividend = (FRAC+1)'(xv); divisor = FRAC'(dv); digit = '0;
    @(negedge clk);
    start = 1'b0;
    digit = 5'sd7;                               // junk during set-up (R3)
    check_rem("R2 load", 128'(xv));
    check(busy == 1'b1, "R2 busy", busy, 1);
    check(done == 1'b0, "R7 done cleared", done, 0);
    @(negedge clk);
    check_rem("R3 setup hold", 128'(xv));
    w = 128'(xv); qacc = '0;
    for (int j = 0; j < ITERS; j++) begin
      if (j > 0) check_rem("R4 iter", w);
      if (forced) begin
        qq = 128'(((j * 7 + seed) % 19) - 9);
      end else begin
        if (j > 0) check(5 * (w < 0 ? -w : w) <= 3 * 128'(dv), "R8 bound",
                         longint'(w), longint'(dv));
        num = 32 * w + 128'(dv);
        den = 2 * 128'(dv);
        qq  = num / den;
        if (num < 0 && (num % den) != 0) qq = qq - 1;
        if (qq > 9) qq = 9;
        if (qq < -9) qq = -9;
      end
      digit = 5'(qq);
      qacc  = qacc * 16 + qq;
      w     = 16 * w - qq * 128'(dv);
      @(negedge clk);
    end
    check_rem("R4 last", w);
    check(done == 1'b1, "R6 done", done, 1);
    check(busy == 1'b0, "R6 busy low", busy, 0);
    if (!forced) begin
      check(5 * (w < 0 ? -w : w) <= 3 * 128'(dv), "R8 final bound", longint'(w), longint'(dv));
      lhs = 128'(xv) <<< (4 * ITERS);
      rhs = qacc * 128'(dv) + w;
      check(lhs == rhs, "R8 identity", longint'(rhs - lhs), 0);
    end
    digit = -5'sd9;                              // ignored after completion
    repeat (2) @(negedge clk);
    check_rem("R6 hold after done", w);
    check(done == 1'b1, "R7 done held", done, 1);
  endtask

  initial begin
    #(8 * 200000);
    if (!finished) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    check(busy == 1'b0, "R1 busy", busy, 0);
    check(done == 1'b0, "R1 done", done, 0);
    check_rem("R1 rem", '0);
    // R9: digit has no effect while idle
    digit = -5'sd8;
    repeat (3) @(negedge clk);
    check_rem("R9 idle hold", '0);

    // table of operand pairs, rounded digit selection (R4, R8)
    for (int v = 0; v < NV; v++) run_div(VX[v], VD[v], 1'b0, 0);

    // forced digit sweeps covering every value -9..9 (R4, R5)
    run_div(0, 40000, 1'b1, 0);
    run_div(3000, 65535, 1'b1, 5);
    run_div(-1500, 4097, 1'b1, 11);

    // R7: restart in the middle of a division
    @(negedge clk);
    start = 1'b1; dividend = 17'sd500; divisor = 16'd30000;
    @(negedge clk);
    start = 1'b0; digit = 5'sd4;
    repeat (5) @(negedge clk);
    check(busy == 1'b1, "R7 mid-run busy", busy, 1);
    run_div(-7777, 30001, 1'b0, 0);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule